// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is the management-bus master for Ethernet PHYs. It generates the MDC clock and drives the bidirectional MDIO line as a split output, output-enable and input triple. Software reaches it through four 32-bit registers on a simple word-addressed write strobe with a combinational read port. Both Clause 22 and Clause 45 frame encodings are supported, and a status bit selects between them.

Software first sets the clock divider and the encoding. It then writes the port and device addresses into the control register. A frame starts from one of three writes. Writing the data register sends a write frame. Writing the control register with its read bit set sends a read frame. In Clause 45 mode, writing the address register sends an address frame. A busy flag is high while a frame is on the wire. For reads, the captured value lands in the data register. A read-error flag reports that the PHY did not pull the line low in the second turnaround bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status register reads 0x00000A00 (default divider 10, Clause 22, not busy, no error). The control, data and address registers read zero, MDC is low and MDIO is not driven (output enable low).
- R2: The registers sit at word offsets 12 (status), 13 (control), 14 (data) and 15 (address); any other offset reads zero. Status fields: bit 0 busy, bit 1 read error, bit 6 Clause 45 select, bits 15:8 divider. Control fields: bits 4:0 device or register number, bits 9:5 port, bit 10 preamble suppress, bit 15 read launch. Bit 15 always reads back zero, and all unlisted bits read zero.
- R3: While busy, MDC toggles every max(divider,1) clock cycles, so its period is 2*max(divider,1) clocks. MDC is low when idle.
- R4: Every frame begins with 32 one-bits of preamble unless control bit 10 is set, in which case the frame is 32 bits long.
- R5: Clause 22 frames send start 01, then opcode 01 (write) or 10 (read), then the 5-bit port, the 5-bit register number, turnaround 10 on writes, and 16 data bits, each field MSB first.
- R6: Clause 45 frames send start 00 and opcode 00 (address), 01 (write) or 11 (read), with the same field layout; address frames carry the address-register value as payload.
- R7: A data write starts a write frame and a control write with bit 15 set starts a read frame. An address write starts an address frame only in Clause 45 mode; in Clause 22 mode it only stores the value.
- R8: The master changes MDIO only after MDC falling edges, so each bit is stable across the MDC rising edge on which it is sampled. The master samples the PHY on MDC rising edges.
- R9: On a read, MDIO is released from the first turnaround bit to the end of the frame. The 16 bits that follow the turnaround are captured MSB first and appear in the low half of the data register when busy clears.
- R10: The read-error flag is set when the second turnaround bit of a read is sampled high, and it clears when the next read frame starts.
- R11: Busy reads 1 from the clock after a launching write until the clock edge of the last MDC falling edge of the frame.
- R12: Every register write made while busy is high is ignored: it changes no field and starts no frame.
- R13: The data register keeps the captured read value until a later register write or read replaces it, so it stays valid well beyond 16 MDC cycles after busy clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | High when the master drives MDIO |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The assertions assume that software keeps the divider and encoding fixed while a frame runs. That holds because writes during busy are dropped. They also assume that reg_wr is a clean one-cycle strobe. The bench drives every register access on the falling clock edge as a single-cycle pulse. It changes mdio_in only just after an MDC rising edge, behaving like a PHY that answers in the following bit. The model answers only while a read has released the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_W      = 32;
  localparam int DIV_W      = 8;
  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;

  // word offsets of the four registers
  localparam logic [3:0] OFS_STAT = 4'd12;
  localparam logic [3:0] OFS_CTL  = 4'd13;
  localparam logic [3:0] OFS_DATA = 4'd14;
  localparam logic [3:0] OFS_ADDR = 4'd15;

  // field positions
  localparam int ST_BUSY   = 0;
  localparam int ST_RDERR  = 1;
  localparam int ST_C45    = 6;
  localparam int ST_DIV_LO = 8;
  localparam int CT_NOPRE  = 10;
  localparam int CT_RDGO   = 15;

  // first frame bit index at which a read releases the line
  localparam int TA_FIRST = 14;
  localparam int TA_ACK   = 15;
  localparam int DAT_LO   = 16;

  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2
  } frame_kind_e;

  typedef struct packed {
    frame_kind_e kind;
    logic        c45;
    logic        nopre;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] payload;
  } frame_req_t;

  // half period of MDC in clock cycles; zero behaves as one
  function automatic logic [DIV_W-1:0] mdio_half(input logic [DIV_W-1:0] div);
    return (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
  endfunction

  function automatic logic [1:0] mdio_opcode(input logic c45, input frame_kind_e kind);
    logic [1:0] op;
    case (kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      FK_READ:  op = c45 ? 2'b11 : 2'b10;
      default:  op = 2'b00;
    endcase
    return op;
  endfunction

  // 32-bit frame after the preamble, MSB goes out first
  function automatic logic [FRAME_BITS-1:0] mdio_frame_word(input frame_req_t r);
    logic [1:0] st;
    st = r.c45 ? 2'b00 : 2'b01;
    return {st, mdio_opcode(r.c45, r.kind), r.port, r.dev, 2'b10, r.payload};
  endfunction

  // index of the last bit of a frame
  function automatic logic [5:0] mdio_last_idx(input logic nopre);
    return nopre ? 6'(FRAME_BITS - 1) : 6'(FRAME_BITS + PRE_BITS - 1);
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = en && (cnt == half - 1'b1);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the clock rests low whenever no frame is active
  p_mdc_rest_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  // R3: the phase counter never passes the half period while running
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && $stable(half) |-> cnt < half);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  frame_req_t  req,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_in,
  output logic        busy,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        done,
  output logic        done_read,
  output logic        rd_ack,
  output logic [15:0] rd_data
);

  frame_req_t            cur;
  logic [FRAME_BITS-1:0] word;
  logic [5:0]            cnt;
  logic                  in_frame;
  logic [4:0]            fidx;
  logic                  last;
  logic                  is_rd;
  logic                  released;

  assign in_frame  = cur.nopre || cnt[5];
  assign fidx      = cnt[4:0];
  assign last      = (cnt == mdio_last_idx(cur.nopre));
  assign is_rd     = (cur.kind == FK_READ);
  assign released  = is_rd && in_frame && (fidx >= 5'(TA_FIRST));

  assign mdio_out  = (busy && in_frame) ? word[5'd31 - fidx] : 1'b1;
  assign mdio_oe   = busy && !released;
  assign done      = busy && fall_evt && last;
  assign done_read = done && is_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur     <= '0;
      word    <= '1;
      cnt     <= '0;
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        cur     <= req;
        word    <= mdio_frame_word(req);
        cnt     <= '0;
        rd_ack  <= 1'b0;
        rd_data <= '0;
      end
    end else begin
      if (rise_evt && is_rd && in_frame) begin
        if (fidx == 5'(TA_ACK)) rd_ack <= !mdio_in;
        if (fidx >= 5'(DAT_LO)) rd_data <= {rd_data[14:0], mdio_in};
      end
      if (fall_evt) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
    end
  end

  // R8: line value and enable move only on the MDC falling edge
  p_out_on_fall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fall_evt |=> $stable(mdio_out) && $stable(mdio_oe));

  // R9: at the end of a read the master is not driving
  p_read_tail_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_read |-> !mdio_oe);

  // R12: a start request during a frame leaves the frame untouched
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy && $stable(word));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [DIV_W-1:0] DIV_INIT = 8'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done_read,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data,
  output logic              start,
  output frame_req_t        req,
  output logic [DIV_W-1:0]  half
);

  logic             c45_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       dev_q;
  logic [4:0]       port_q;
  logic             nopre_q;
  logic [15:0]      data_q;
  logic [15:0]      addr_q;
  logic             err_q;

  logic accept;
  logic hit_stat, hit_ctl, hit_data, hit_addr;
  logic go_write, go_read, go_addr;

  assign accept   = wr_en && !busy;
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_ctl  = (addr == ADDR_W'(OFS_CTL));
  assign hit_data = (addr == ADDR_W'(OFS_DATA));
  assign hit_addr = (addr == ADDR_W'(OFS_ADDR));

  assign go_write = accept && hit_data;
  assign go_read  = accept && hit_ctl && wdata[CT_RDGO];
  assign go_addr  = accept && hit_addr && c45_q;
  assign start    = go_write || go_read || go_addr;
  assign half     = mdio_half(div_q);

  always_comb begin
    req.c45     = c45_q;
    req.kind    = go_read ? FK_READ : (go_addr ? FK_ADDR : FK_WRITE);
    req.nopre   = hit_ctl ? wdata[CT_NOPRE] : nopre_q;
    req.port    = hit_ctl ? wdata[9:5] : port_q;
    req.dev     = hit_ctl ? wdata[4:0] : dev_q;
    req.payload = go_read ? 16'hFFFF : wdata[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c45_q   <= 1'b0;
      div_q   <= DIV_INIT;
      dev_q   <= '0;
      port_q  <= '0;
      nopre_q <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept && hit_stat) begin
        c45_q <= wdata[ST_C45];
        div_q <= wdata[ST_DIV_LO +: DIV_W];
      end
      if (accept && hit_ctl) begin
        dev_q   <= wdata[4:0];
        port_q  <= wdata[9:5];
        nopre_q <= wdata[CT_NOPRE];
      end
      if (go_read)              err_q  <= 1'b0;
      if (accept && hit_data)   data_q <= wdata[15:0];
      if (accept && hit_addr)   addr_q <= wdata[15:0];
      if (done_read) begin
        data_q <= rd_data;
        err_q  <= !rd_ack;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (1'b1)
      hit_stat: begin
        rdata[ST_BUSY]              = busy;
        rdata[ST_RDERR]             = err_q;
        rdata[ST_C45]               = c45_q;
        rdata[ST_DIV_LO +: DIV_W]   = div_q;
      end
      hit_ctl: begin
        rdata[4:0]      = dev_q;
        rdata[9:5]      = port_q;
        rdata[CT_NOPRE] = nopre_q;
      end
      hit_data: rdata[15:0] = data_q;
      hit_addr: rdata[15:0] = addr_q;
      default:  rdata = '0;
    endcase
  end

  // R12: configuration cannot move while a frame is running
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_q) && $stable(c45_q) && $stable(port_q) && $stable(dev_q));

  // R10: the error flag only rises at the end of a read
  p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(done_read));

  // R10: a new read clears the error flag
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_read |=> !err_q);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int               ADDR_W   = 4,
  parameter logic [DIV_W-1:0] DIV_INIT = 8'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);

  frame_req_t       req;
  logic             start;
  logic             busy;
  logic             done;
  logic             done_read;
  logic             rd_ack;
  logic [15:0]      rd_data;
  logic [DIV_W-1:0] half;
  logic             rise_evt;
  logic             fall_evt;

  mdio_regs #(
    .ADDR_W   (ADDR_W),
    .DIV_INIT (DIV_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .done_read (done_read),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .start     (start),
    .req       (req),
    .half      (half)
  );

  mdio_clkgen #(
    .DIV_W (DIV_W)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (busy),
    .half     (half),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req       (req),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mdio_in   (mdio_in),
    .busy      (busy),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .done_read (done_read),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data)
  );

  // R11: busy only rises after an accepted launching write
  p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R11: a frame ends with MDC back low
  p_end_mdc_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> !busy && !mdc);

  // R1: the line is released whenever no frame is active
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe && !mdc);

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  typedef struct packed {
    logic [63:0] exp;
    logic [63:0] drv;
    logic [63:0] resp;
    logic [6:0]  n;
    logic [31:0] tag;
  } item_t;

  item_t sb[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected frame per R4, R5, R6, R9: kind 0 addr, 1 write, 2 read
  function automatic item_t mk(input bit c45, input int kind, input logic [4:0] pa,
                               input logic [4:0] da, input logic [15:0] pl,
                               input bit nopre, input bit ack, input logic [15:0] rdat,
                               input logic [31:0] tag);
    item_t it;
    logic [31:0] w;
    logic [1:0] st, op;
    int pre;
    st = c45 ? 2'b00 : 2'b01;
    if (kind == 0) op = 2'b00;
    else if (kind == 1) op = 2'b01;
    else op = c45 ? 2'b11 : 2'b10;
    w = {st, op, pa, da, 2'b10, (kind == 2) ? 16'hFFFF : pl};
    pre = nopre ? 0 : 32;
    it = '0;
    it.tag = tag;
    it.n = 7'(pre + 32);
    for (int i = 0; i < pre + 32; i++) begin
      if (i < pre) begin
        it.exp[i] = 1'b1; it.drv[i] = 1'b1; it.resp[i] = 1'b1;
      end else begin
        int f;
        f = i - pre;
        it.exp[i]  = w[31-f];
        it.drv[i]  = !(kind == 2 && f >= 14);
        it.resp[i] = (f == 15) ? !ack : (f >= 16) ? rdat[31-f] : 1'b1;
      end
    end
    return it;
  endfunction

  // monitor: pops an expected frame at its first MDC rise and compares bit by bit
  initial begin
    forever begin
      @(posedge mdc);
      #1;
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 actual=unexpected frame expected=no frame");
        mdio_in = 1'b1;
        wait (mdc == 1'b0);
      end else begin
        item_t it;
        int errs;
        it = sb.pop_front();
        errs = 0;
        for (int i = 0; i < int'(it.n); i++) begin
          if (it.drv[i]) begin
            if (mdio_oe !== 1'b1 || mdio_out !== it.exp[i]) begin
              if (errs == 0)
                $display("FAIL %s bit %0d actual=oe%b/%b expected=oe1/%b",
                         it.tag, i, mdio_oe, mdio_out, it.exp[i]);
              errs++;
            end
          end else if (mdio_oe !== 1'b0) begin
            if (errs == 0)
              $display("FAIL %s bit %0d actual=oe%b expected=oe0", it.tag, i, mdio_oe);
            errs++;
          end
          mdio_in = (i + 1 < int'(it.n)) ? it.resp[i+1] : 1'b1;
          if (i + 1 < int'(it.n)) begin
            @(posedge mdc);
            #1;
          end
        end
        total++;   // R8 bit timing, frame content per tag
        if (errs != 0) bad++;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(4'd12, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic mdc_period(output time p);
    time t0;
    @(posedge mdc); t0 = $time;
    @(posedge mdc); p = $time - t0;
  endtask

  initial begin
    logic [31:0] v;
    time per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd12, v); check("R1 status", v, 32'h00000A00);
    rd(4'd13, v); check("R1 control", v, 32'h0);
    rd(4'd14, v); check("R1 data", v, 32'h0);
    check("R1 mdc/oe", {30'd0, mdc, mdio_oe}, 32'h0);

    // R2 register fields
    wr(4'd12, 32'h0000_0200);
    rd(4'd12, v); check("R2 status", v, 32'h0000_0200);
    wr(4'd13, 32'hFFFF_4871 & 32'h0000_0071);
    rd(4'd13, v); check("R2 control", v, 32'h0000_0071);

    // R5 Clause 22 write; R11 busy; R3 period; R12 writes ignored while busy
    sb.push_back(mk(0, 1, 5'h03, 5'h11, 16'hBEEF, 0, 0, 16'h0, "R5"));
    wr(4'd14, 32'h0000_BEEF);
    rd(4'd12, v); check("R11 busy", v, 32'h0000_0201);
    mdc_period(per); check("R3 period div2", 32'(per), 32'(4*CLK_PERIOD));
    wr(4'd13, 32'h0000_83FF);
    wr(4'd14, 32'h0000_1111);
    wr(4'd12, 32'h0000_0740);
    wait_idle();
    rd(4'd13, v); check("R12 control", v, 32'h0000_0071);
    rd(4'd14, v); check("R12 data", v, 32'h0000_BEEF);
    rd(4'd12, v); check("R12 status", v, 32'h0000_0200);

    // R9 Clause 22 read with acknowledge
    sb.push_back(mk(0, 2, 5'h03, 5'h11, 16'h0, 0, 1, 16'h1234, "R9"));
    wr(4'd13, 32'h0000_8071);
    wait_idle();
    rd(4'd14, v); check("R9 read data", v, 32'h0000_1234);
    rd(4'd12, v); check("R10 no error", v, 32'h0000_0200);
    rd(4'd13, v); check("R2 read bit reads 0", v, 32'h0000_0071);

    // R10 read without acknowledge, then clear on next read
    sb.push_back(mk(0, 2, 5'h03, 5'h11, 16'h0, 0, 0, 16'hFFFF, "R10"));
    wr(4'd13, 32'h0000_8071);
    wait_idle();
    rd(4'd12, v); check("R10 error set", v, 32'h0000_0202);
    sb.push_back(mk(0, 2, 5'h03, 5'h11, 16'h0, 0, 1, 16'h5A5A, "R9"));
    wr(4'd13, 32'h0000_8071);
    rd(4'd12, v); check("R10 error cleared at start", v, 32'h0000_0201);
    wait_idle();
    rd(4'd14, v); check("R9 second read", v, 32'h0000_5A5A);

    // R4 preamble suppressed
    wr(4'd13, 32'h0000_0471);
    sb.push_back(mk(0, 1, 5'h03, 5'h11, 16'h00FF, 1, 0, 16'h0, "R4"));
    wr(4'd14, 32'h0000_00FF);
    wait_idle();
    rd(4'd13, v); check("R4 control", v, 32'h0000_0471);

    // R6 Clause 45 address, write, read
    wr(4'd12, 32'h0000_0240);
    rd(4'd12, v); check("R6 status c45", v, 32'h0000_0240);
    wr(4'd13, 32'h0000_00E1);
    sb.push_back(mk(1, 0, 5'h07, 5'h01, 16'h4321, 0, 0, 16'h0, "R6"));
    wr(4'd15, 32'h0000_4321);
    wait_idle();
    rd(4'd15, v); check("R7 address stored", v, 32'h0000_4321);
    sb.push_back(mk(1, 1, 5'h07, 5'h01, 16'hCAFE, 0, 0, 16'h0, "R6"));
    wr(4'd14, 32'h0000_CAFE);
    wait_idle();
    sb.push_back(mk(1, 2, 5'h07, 5'h01, 16'h0, 0, 1, 16'hA5C3, "R6"));
    wr(4'd13, 32'h0000_80E1);
    wait_idle();
    rd(4'd14, v); check("R6 c45 read data", v, 32'h0000_A5C3);

    // R13 data holds long after busy clears
    repeat (200) @(negedge clk);
    rd(4'd14, v); check("R13 data held", v, 32'h0000_A5C3);

    // R7 address write in Clause 22 mode: stored, no frame
    wr(4'd12, 32'h0000_0200);
    wr(4'd15, 32'h0000_0777);
    rd(4'd12, v); check("R7 no frame", v, 32'h0000_0200);
    rd(4'd15, v); check("R7 address value", v, 32'h0000_0777);
    repeat (50) @(negedge clk);

    // R2 unmapped offset
    rd(4'd3, v); check("R2 unmapped", v, 32'h0);

    // R3 divider zero behaves as one
    wr(4'd12, 32'h0000_0000);
    sb.push_back(mk(0, 1, 5'h07, 5'h01, 16'h0001, 0, 0, 16'h0, "R3"));
    wr(4'd14, 32'h0000_0001);
    mdc_period(per); check("R3 period div0", 32'(per), 32'(2*CLK_PERIOD));
    wait_idle();
    repeat (20) @(negedge clk);
    check("R7 scoreboard drained", 32'(sb.size()), 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule